// File: doc/BRIEF.md
# Station Address Filter with Setup-Image Loading

This block decides whether a received frame is kept, using only its 48-bit destination address. It holds a table of sixteen exact-match station addresses. Software fills the table by streaming a setup image in as 32-bit words, then issuing a load command with the image length in bytes. The block then filters each destination address presented to it, using the table and four mode controls: promiscuous, receive-all, pass-all-multicast and inverse matching.

Setup words are collected in a staging store as they arrive. The live table is replaced in one step, and only when the load command carries the full image length of 192 bytes. Each entry takes three consecutive words of the image. Only the low half of each word carries address bytes, so the upper sixteen bits of every word are discarded.

Address checks are single-cycle strobes. The block compares the address against all sixteen entries at once, runs a fixed priority chain, and registers the accept decision and two status flags one cycle after the strobe. The two flags are filtering-failed, raised when a mode bypasses filtering, and multicast-hit. Address byte 0 is the first byte on the wire and sits at `dstAddr[47:40]`. Its bit 0 (`dstAddr[40]`) is the group bit.

Top module: `stn_addr_filter`

## Requirements
- R1: After reset every table entry is all zeros and `resultValid`, `accept`, `filtFail`, `mcastHit` and `setupDone` are low, so a first lookup of the all-zero address, with no mode set, is accepted by perfect match with no flag raised.
- R2: `resultValid` is high in exactly the cycle after each cycle with `addrValid` high. `accept`, `filtFail` and `mcastHit` are low whenever `resultValid` is low.
- R3: A `setupLoad` pulse with `setupLen` equal to 192 replaces all sixteen entries with the staged image, and `setupDone` is high in the following cycle.
- R4: A `setupLoad` pulse with any other `setupLen` leaves the table unchanged, and `setupDone` is still high in the following cycle.
- R5: Setup words are numbered from 0 after reset or after any `setupLoad`. Word 3n+k fills address bytes 2k (from bits 7:0) and 2k+1 (from bits 15:8) of entry n. Bits 31:16 of every word are ignored, and words past the 48th are dropped.
- R6: The all-ones address is always accepted with both flags low, whatever the mode controls say.
- R7: For a non-broadcast address with `modePromisc` or `modeRxAll` set, the frame is accepted, `filtFail` is high and `mcastHit` is low.
- R8: Otherwise, with `modePassMcast` set and `dstAddr[40]` equal to 1, the frame is accepted, `mcastHit` is high and `filtFail` is low.
- R9: Otherwise `accept` is high exactly when the address equals one of the sixteen entries, and both flags are low.
- R10: With `modeInvert` set, the perfect-match result of R9 is inverted.
- R11: The priority order is broadcast, then promiscuous/receive-all, then pass-all-multicast, then perfect match. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupWrEn | input | 1 | Setup word write strobe |
| setupWord | input | 32 | Setup image word |
| setupLoad | input | 1 | Load command for the staged image |
| setupLen | input | 12 | Setup image length in bytes |
| setupDone | output | 1 | Setup operation complete, one cycle after the load |
| addrValid | input | 1 | Destination address strobe |
| dstAddr | input | 48 | Destination address, byte 0 in bits 47:40 |
| modePromisc | input | 1 | Promiscuous mode |
| modeRxAll | input | 1 | Receive-all mode |
| modePassMcast | input | 1 | Pass all multicast frames |
| modeInvert | input | 1 | Invert the perfect-match result |
| resultValid | output | 1 | Decision valid |
| accept | output | 1 | Frame accepted |
| filtFail | output | 1 | Accepted without filtering (promiscuous/receive-all) |
| mcastHit | output | 1 | Accepted as multicast via pass-all-multicast |

## Verification
Lookups use listed entries at the first, a middle and the last table position, unlisted unicast addresses, multicast addresses, and the broadcast address. Together these separate a real match from a default accept, and one position from another. One probe uses the discarded upper halves of the setup words as address bytes, which would only match if the sparse byte placement were wrong. A load with the wrong length is followed by lookups of both the old and the new entries, to show the table did not change. Mode combinations that stack two rules at once (promiscuous with pass-multicast, pass-multicast with inversion, broadcast with inversion) show which rule of the priority chain wins and which flag it leaves behind.

// File: rtl/saf_pkg.sv
package saf_pkg;
  localparam int ENT_NUM     = 16;
  localparam int ENT_IDX_W   = $clog2(ENT_NUM);
  localparam int ADDR_W      = 48;
  localparam int WORD_W      = 32;
  localparam int LEN_W       = 12;
  localparam int PARTS       = 3;
  localparam int SLOT_BYTES  = 12;
  localparam int SETUP_BYTES = ENT_NUM * SLOT_BYTES;

  typedef struct packed {
    logic                 stageWr;
    logic [ENT_IDX_W-1:0] stageEnt;
    logic [1:0]           stagePart;
    logic                 commit;
    logic                 evalEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/saf_ctrl.sv
module saf_ctrl
  import saf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 setupWrEn,
  input  logic                 setupLoad,
  input  logic [LEN_W-1:0]     setupLen,
  input  logic                 addrValid,
  output logic                 setupDone,
  output ctrlStrobes_t         strb
);
  logic [ENT_IDX_W-1:0] entCnt;
  logic [1:0]           partCnt;
  logic                 full;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entCnt  <= '0;
      partCnt <= '0;
      full    <= 1'b0;
    end else if (setupLoad) begin
      entCnt  <= '0;
      partCnt <= '0;
      full    <= 1'b0;
    end else if (setupWrEn && !full) begin
      if (partCnt == 2'(PARTS - 1)) begin
        partCnt <= '0;
        if (entCnt == ENT_IDX_W'(ENT_NUM - 1)) full <= 1'b1;
        else entCnt <= entCnt + 1'b1;
      end else begin
        partCnt <= partCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) setupDone <= 1'b0;
    else       setupDone <= setupLoad;
  end

  always_comb begin
    strb.stageWr   = setupWrEn && !full && !setupLoad;
    strb.stageEnt  = entCnt;
    strb.stagePart = partCnt;
    strb.commit    = setupLoad && (setupLen == LEN_W'(SETUP_BYTES));
    strb.evalEn    = addrValid;
  end
endmodule

// File: rtl/saf_datapath.sv
module saf_datapath
  import saf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [WORD_W-1:0] setupWord,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic              modePromisc,
  input  logic              modeRxAll,
  input  logic              modePassMcast,
  input  logic              modeInvert,
  output logic              resultValid,
  output logic              accept,
  output logic              filtFail,
  output logic              mcastHit
);
  logic [ADDR_W-1:0] stageAddr [ENT_NUM];
  logic [ADDR_W-1:0] tblAddr   [ENT_NUM];
  logic [ENT_NUM-1:0] hitVec;
  logic [15:0] lowHalf;

  assign lowHalf = setupWord[15:0];

  genvar g;
  generate
    for (g = 0; g < ENT_NUM; g++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stageAddr[g] <= '0;
        end else if (strb.stageWr && strb.stageEnt == ENT_IDX_W'(g)) begin
          case (strb.stagePart)
            2'd0:    stageAddr[g][47:32] <= {lowHalf[7:0], lowHalf[15:8]};
            2'd1:    stageAddr[g][31:16] <= {lowHalf[7:0], lowHalf[15:8]};
            default: stageAddr[g][15:0]  <= {lowHalf[7:0], lowHalf[15:8]};
          endcase
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN)            tblAddr[g] <= '0;
        else if (strb.commit) tblAddr[g] <= stageAddr[g];
      end

      assign hitVec[g] = (tblAddr[g] == dstAddr);
    end
  endgenerate

  logic isBcast, isGroup, anyHit;
  logic nxtAcc, nxtFf, nxtMf;

  assign isBcast = &dstAddr;
  assign isGroup = dstAddr[40];
  assign anyHit  = |hitVec;

  always_comb begin
    nxtAcc = 1'b0;
    nxtFf  = 1'b0;
    nxtMf  = 1'b0;
    if (isBcast) begin
      nxtAcc = 1'b1;
    end else if (modePromisc || modeRxAll) begin
      nxtAcc = 1'b1;
      nxtFf  = 1'b1;
    end else if (modePassMcast && isGroup) begin
      nxtAcc = 1'b1;
      nxtMf  = 1'b1;
    end else begin
      nxtAcc = anyHit ^ modeInvert;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      accept      <= 1'b0;
      filtFail    <= 1'b0;
      mcastHit    <= 1'b0;
    end else begin
      resultValid <= strb.evalEn;
      accept      <= strb.evalEn && nxtAcc;
      filtFail    <= strb.evalEn && nxtFf;
      mcastHit    <= strb.evalEn && nxtMf;
    end
  end
endmodule

// File: rtl/stn_addr_filter.sv
module stn_addr_filter
  import saf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        setupWrEn,
  input  logic [31:0] setupWord,
  input  logic        setupLoad,
  input  logic [11:0] setupLen,
  output logic        setupDone,
  input  logic        addrValid,
  input  logic [47:0] dstAddr,
  input  logic        modePromisc,
  input  logic        modeRxAll,
  input  logic        modePassMcast,
  input  logic        modeInvert,
  output logic        resultValid,
  output logic        accept,
  output logic        filtFail,
  output logic        mcastHit
);
  ctrlStrobes_t strb;

  saf_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .setupWrEn (setupWrEn),
    .setupLoad (setupLoad),
    .setupLen  (setupLen),
    .addrValid (addrValid),
    .setupDone (setupDone),
    .strb      (strb)
  );

  saf_datapath uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .setupWord     (setupWord),
    .dstAddr       (dstAddr),
    .modePromisc   (modePromisc),
    .modeRxAll     (modeRxAll),
    .modePassMcast (modePassMcast),
    .modeInvert    (modeInvert),
    .resultValid   (resultValid),
    .accept        (accept),
    .filtFail      (filtFail),
    .mcastHit      (mcastHit)
  );
endmodule

// File: rtl/saf_checker.sv
module saf_checker (
  input logic        clk,
  input logic        rstN,
  input logic        setupLoad,
  input logic        setupDone,
  input logic        addrValid,
  input logic [47:0] dstAddr,
  input logic        modePromisc,
  input logic        modeRxAll,
  input logic        resultValid,
  input logic        accept,
  input logic        filtFail,
  input logic        mcastHit
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> resultValid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !resultValid);
  a_r2_quiet_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> !accept && !filtFail && !mcastHit);
  a_r3_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    setupLoad |=> setupDone);
  a_r6_bcast_clean: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && (dstAddr == 48'hFFFF_FFFF_FFFF) |=> accept && !filtFail && !mcastHit);
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && (dstAddr != 48'hFFFF_FFFF_FFFF) && (modePromisc || modeRxAll)
      |=> accept && filtFail && !mcastHit);
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(filtFail && mcastHit));
endmodule

bind stn_addr_filter saf_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .setupLoad   (setupLoad),
  .setupDone   (setupDone),
  .addrValid   (addrValid),
  .dstAddr     (dstAddr),
  .modePromisc (modePromisc),
  .modeRxAll   (modeRxAll),
  .resultValid (resultValid),
  .accept      (accept),
  .filtFail    (filtFail),
  .mcastHit    (mcastHit)
);

// File: tb/sim_stn_addr_filter.sv
`timescale 1ns/1ps
module sim_stn_addr_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupWrEn = 1'b0;
  logic [31:0] setupWord = '0;
  logic        setupLoad = 1'b0;
  logic [11:0] setupLen = '0;
  logic        setupDone;
  logic        addrValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic        modePromisc = 1'b0, modeRxAll = 1'b0, modePassMcast = 1'b0, modeInvert = 1'b0;
  logic        resultValid, accept, filtFail, mcastHit;

  int nChecks = 0;
  int nFails  = 0;
  logic [47:0] refTbl [16];

  always #2.5 clk = ~clk;

  stn_addr_filter u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] addrA(input int n);
    if (n == 3) return {8'h03, 8'h11, 8'h22, 8'h33, 8'h40, 8'(n)};
    return {8'h02, 8'h11, 8'h22, 8'h33, 8'h40, 8'(n)};
  endfunction

  function automatic logic [47:0] addrB(input int n);
    return {8'h06, 8'h77, 8'h88, 8'h99, 8'hA0, 8'(n)};
  endfunction

  function automatic logic [2:0] model(input logic [47:0] a, input logic pr, input logic ra,
                                       input logic pm, input logic inv);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < 16; i++) if (refTbl[i] == a) hit = 1'b1;
    if (&a) return 3'b100;
    if (pr || ra) return 3'b110;
    if (pm && a[40]) return 3'b101;
    return {hit ^ inv, 2'b00};
  endfunction

  task automatic probe(input string req, input logic [47:0] a);
    logic [2:0] e;
    e = model(a, modePromisc, modeRxAll, modePassMcast, modeInvert);
    @(negedge clk);
    addrValid = 1'b1;
    dstAddr   = a;
    @(negedge clk);
    addrValid = 1'b0;
    check({req, " valid"}, 32'(resultValid), 32'd1);
    check({req, " accept"}, 32'(accept), 32'(e[2]));
    check({req, " filtFail"}, 32'(filtFail), 32'(e[1]));
    check({req, " mcastHit"}, 32'(mcastHit), 32'(e[0]));
  endtask

  task automatic load_image(input bit useB, input int len, input string req);
    logic [47:0] a;
    for (int n = 0; n < 16; n++) begin
      a = useB ? addrB(n) : addrA(n);
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        setupWrEn = 1'b1;
        setupWord = {16'hDEAD ^ 16'(n * 3 + p), a[39 - 16*p -: 8], a[47 - 16*p -: 8]};
      end
    end
    @(negedge clk);
    setupWord = 32'hFFFF_FFFF;
    @(negedge clk);
    setupWrEn = 1'b0;
    setupLoad = 1'b1;
    setupLen  = 12'(len);
    @(negedge clk);
    setupLoad = 1'b0;
    check({req, " setupDone"}, 32'(setupDone), 32'd1);
    @(negedge clk);
    check({req, " setupDone drop"}, 32'(setupDone), 32'd0);
    if (len == 192)
      for (int n = 0; n < 16; n++) refTbl[n] = useB ? addrB(n) : addrA(n);
  endtask

  task automatic t_reset();
    check("R1 setupDone", 32'(setupDone), 32'd0);
    check("R1 resultValid", 32'(resultValid), 32'd0);
    check("R1 flags", 32'({accept, filtFail, mcastHit}), 32'd0);
    probe("R1 zero-address hit", 48'h0);
    check("R2 single-cycle valid", 32'(resultValid), 32'd1);
    @(negedge clk);
    check("R2 valid drops", 32'(resultValid), 32'd0);
    check("R2 accept drops", 32'(accept), 32'd0);
  endtask

  task automatic t_load_and_match();
    load_image(1'b0, 192, "R3 full load");
    probe("R9 entry 0", addrA(0));
    probe("R9 entry 7", addrA(7));
    probe("R9 entry 15", addrA(15));
    probe("R9 unlisted", 48'h02_11_22_33_41_00);
    probe("R3 old zero gone", 48'h0);
    probe("R5 upper half bytes", {8'hDE, 8'hAD, 8'hDE, 8'hAC, 8'hDE, 8'hAF});
    probe("R5 word 48 dropped", 48'hFFFF_FFFF_FFFE);
  endtask

  task automatic t_short_load();
    load_image(1'b1, 128, "R4 short load");
    probe("R4 old entry kept", addrA(5));
    probe("R4 new entry absent", addrB(5));
  endtask

  task automatic t_bcast();
    modeInvert = 1'b1;
    probe("R6 bcast inverted", 48'hFFFF_FFFF_FFFF);
    modeInvert = 1'b0; modePassMcast = 1'b1;
    probe("R6 bcast passmc", 48'hFFFF_FFFF_FFFF);
    modePassMcast = 1'b0;
  endtask

  task automatic t_promisc();
    modePromisc = 1'b1;
    probe("R7 promisc unicast", 48'h12_34_56_78_9A_BC);
    modePromisc = 1'b0; modeRxAll = 1'b1;
    probe("R7 rxall unicast", 48'h12_34_56_78_9A_BC);
    modeRxAll = 1'b0;
  endtask

  task automatic t_passmc();
    modePassMcast = 1'b1;
    probe("R8 mcast unlisted", 48'h01_00_5E_00_00_01);
    probe("R8 unicast unlisted", 48'h02_00_5E_00_00_01);
    probe("R8 unicast listed", addrA(2));
    modePassMcast = 1'b0;
    probe("R9 mcast no passmc", 48'h01_00_5E_00_00_01);
  endtask

  task automatic t_invert();
    modeInvert = 1'b1;
    probe("R10 listed rejected", addrA(9));
    probe("R10 unlisted accepted", 48'h0A_0B_0C_0D_0E_0F);
    modeInvert = 1'b0;
  endtask

  task automatic t_priority();
    modePromisc = 1'b1; modePassMcast = 1'b1;
    probe("R11 promisc over passmc", 48'h01_00_5E_00_00_02);
    modePromisc = 1'b0; modeInvert = 1'b1;
    probe("R11 passmc over invert", addrA(3));
    modePassMcast = 1'b0;
    probe("R11 invert listed mcast", addrA(3));
    modeInvert = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) refTbl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and_match();
    t_short_load();
    t_bcast();
    t_promisc();
    t_passmc();
    t_invert();
    t_priority();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule